// File: doc/BRIEF.md
# Codec Control Serial Write Master

This block issues register writes to one of two codec chips over a three-wire control port: a shared serial data line, a shared serial clock and one active-low select per chip. A host presents a chip index, a 5-bit register address, an 8-bit value and an 8-bit bit-enable mask in a single cycle. The block merges the value into its local shadow copy of that register, builds a 16-bit command word, shifts it out most significant bit first and pulses done once the bus is parked again.

The shadow copy lets the host change a few bits of a codec register without reading it back. Only the enabled bits take the new value; the other bits keep the last value written through this block, starting from zero after reset. A parameter sets the length of one bus phase in clock cycles.

The state machine has seven states. IDLE leaves for PARK when a request is accepted. PARK leaves for SEL, and SEL leaves for BIT_LO, each after one phase. Each bit then goes through BIT_LO, BIT_SET and BIT_HI, one phase each. BIT_HI returns to BIT_LO while bits remain and goes to TAIL after bit 0. TAIL returns to IDLE after one phase and raises done in its last cycle.

Top module: `cctl_serial_master`

## Requirements
- R1: The command word is 16 bits sent most significant bit first. Bits 15:14 hold 2'b10, bit 13 holds 1, bits 12:8 hold the register address and bits 7:0 hold the data byte.
- R2: Out of reset and whenever the block is idle, ser_clk, ser_dat and both ser_cs_n bits are high. Busy and done are low.
- R3: Chip index 0 drives ser_cs_n[0] low and indices 1 to 3 drive ser_cs_n[1] low. At most one select is low at any time.
- R4: Each bit takes three phases: the clock goes low with data unchanged, then the data bit is set, then the clock goes high. Data is stable while the clock is high, so the receiver captures it on the rising clock edge.
- R5: A request with chip index 4 or more is rejected: busy stays low and no select goes low.
- R6: A request is accepted only while busy is low. Requests made while busy have no effect on the frame in flight or on any later frame.
- R7: A transfer lasts 51 phases from acceptance: one phase with all lines high, one phase with the select low before the first bit, 48 bit phases and one closing phase with all lines high. Done is high for exactly one cycle, the last cycle of that closing phase.
- R8: The data byte sent is (shadow & ~mask) | (data & mask). That value becomes the new shadow for the register. Shadows start at zero, and indices 1 to 3 share the second chip's shadow.
- R9: One phase lasts PHASE_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request |
| req_chip | input | 3 | Chip index (0, 1 to 3, 4 or more rejected) |
| req_addr | input | 5 | Codec register address |
| req_data | input | 8 | New register bits |
| req_mask | input | 8 | Bit enables; 1 takes the bit from req_data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| ser_clk | output | 1 | Serial clock, parks high |
| ser_dat | output | 1 | Serial data, parks high |
| ser_cs_n | output | 2 | Active-low chip selects |

## Verification
The assertions assume that a request's fields are only looked at in the cycle it is accepted. They also assume that reset is asserted long enough for the shadow and state to clear before the first request. The bench drives requests away from the clock edge and holds them for one cycle only. It then waits for done before sending the next accepted request. Requests made while busy are extra one-cycle pulses that carry different values, so any wrong capture would show up as a mismatched or extra frame.

// File: rtl/cctl_pkg.sv
package cctl_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = 16;
    localparam logic [2:0] FRAME_HDR = 3'b101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PARK,
        ST_SEL,
        ST_BIT_LO,
        ST_BIT_SET,
        ST_BIT_HI,
        ST_TAIL
    } cctl_state_e;
endpackage

// File: rtl/cctl_shadow_frame.sv
module cctl_shadow_frame
    import cctl_pkg::*;
#(
    parameter int N_CHIPS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(N_CHIPS)-1:0] chip,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          data,
    input  logic [DATA_W-1:0]          mask,
    output logic [FRAME_W-1:0]         frame
);
    localparam int N_REGS = 1 << ADDR_W;

    logic [DATA_W-1:0] shadow [N_CHIPS][N_REGS];
    logic [DATA_W-1:0] merged;

    always_comb begin
        merged = (shadow[chip][addr] & ~mask) | (data & mask);
        frame  = {FRAME_HDR, addr, merged};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CHIPS; c++)
                for (int r = 0; r < N_REGS; r++)
                    shadow[c][r] <= '0;
        end else if (wr_en) begin
            shadow[chip][addr] <= merged;
        end
    end
endmodule

// File: rtl/cctl_phase_timer.sv
module cctl_phase_timer #(
    parameter int PHASE_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cctl_serial_master.sv
module cctl_serial_master
    import cctl_pkg::*;
#(
    parameter int PHASE_CYC = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_chip,
    input  logic [4:0] req_addr,
    input  logic [7:0] req_data,
    input  logic [7:0] req_mask,
    output logic       busy,
    output logic       done,
    output logic       ser_clk,
    output logic       ser_dat,
    output logic [1:0] ser_cs_n
);
    localparam int BIT_W = $clog2(FRAME_W);

    cctl_state_e          st_q, st_d;
    logic [FRAME_W-1:0]   frame_q, frame_w;
    logic [BIT_W-1:0]     bit_q;
    logic                 tgt_q;
    logic                 dat_q;
    logic                 accept, expired, advance, req_tgt;

    assign req_tgt = (req_chip != 3'd0);
    assign accept  = (st_q == ST_IDLE) && req_valid && (req_chip < 3'd4);
    assign advance = (st_q != ST_IDLE) && expired;

    cctl_shadow_frame #(.N_CHIPS(2)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (accept),
        .chip  (req_tgt),
        .addr  (req_addr),
        .data  (req_data),
        .mask  (req_mask),
        .frame (frame_w)
    );

    cctl_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept || advance),
        .expired (expired)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (accept)  st_d = ST_PARK;
            ST_PARK:    if (expired) st_d = ST_SEL;
            ST_SEL:     if (expired) st_d = ST_BIT_LO;
            ST_BIT_LO:  if (expired) st_d = ST_BIT_SET;
            ST_BIT_SET: if (expired) st_d = ST_BIT_HI;
            ST_BIT_HI:  if (expired) st_d = (bit_q == '0) ? ST_TAIL : ST_BIT_LO;
            ST_TAIL:    if (expired) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            frame_q <= '0;
            bit_q   <= '0;
            tgt_q   <= 1'b0;
            dat_q   <= 1'b1;
        end else begin
            st_q <= st_d;
            if (accept) begin
                frame_q <= frame_w;
                tgt_q   <= req_tgt;
                bit_q   <= BIT_W'(FRAME_W - 1);
            end
            if (st_q == ST_BIT_LO && expired)
                dat_q <= frame_q[bit_q];
            if (st_q == ST_BIT_HI && expired) begin
                if (bit_q == '0) dat_q <= 1'b1;
                else             bit_q <= bit_q - 1'b1;
            end
        end
    end

    always_comb begin
        logic sel_on;
        sel_on      = (st_q == ST_SEL) || (st_q == ST_BIT_LO) ||
                      (st_q == ST_BIT_SET) || (st_q == ST_BIT_HI);
        ser_clk     = !((st_q == ST_BIT_LO) || (st_q == ST_BIT_SET));
        ser_dat     = dat_q;
        ser_cs_n[0] = !(sel_on && !tgt_q);
        ser_cs_n[1] = !(sel_on && tgt_q);
        busy        = (st_q != ST_IDLE);
        done        = (st_q == ST_TAIL) && expired;
    end

    a_r2_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (ser_clk && ser_dat && (&ser_cs_n) && !done));

    a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ser_cs_n) <= 1);

    a_r4_data_held_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BIT_HI && $past(st_q) == ST_BIT_HI) |-> $stable(ser_dat));

    a_r5_reject_index: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && req_valid && req_chip >= 3'd4) |=> (st_q == ST_IDLE));

    a_r6_frame_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(frame_q));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: tb/sim_cctl_serial_master.sv
module sim_cctl_serial_master;
    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_chip = '0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic [7:0] req_mask = '0;
    logic       busy, done, ser_clk, ser_dat;
    logic [1:0] ser_cs_n;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    int frames_pushed = 0;
    logic [16:0] exp_q[$];
    logic [7:0]  model [2][32];

    always #2 clk = ~clk;

    cctl_serial_master #(.PHASE_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chip(req_chip),
        .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
        .busy(busy), .done(done), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_cs_n(ser_cs_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: rebuilds frames from the bus and pops the scoreboard
    initial begin
        logic [15:0] sh;
        int nbits;
        logic pclk, pdat, seq_bad, tgt;
        logic [1:0] pcs;
        logic [16:0] e;
        pclk = 1; pdat = 1; pcs = 2'b11; sh = '0; nbits = 0; seq_bad = 0; tgt = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pcs == 2'b11 && ser_cs_n != 2'b11) begin
                    nbits = 0; sh = '0; seq_bad = 0;
                    tgt = (ser_cs_n == 2'b01);
                end
                if (ser_cs_n != 2'b11) begin
                    if (pclk && !ser_clk && ser_dat != pdat) seq_bad = 1;
                    if (!pclk && ser_clk) begin
                        sh = {sh[14:0], ser_dat}; nbits++;
                    end
                    if (ser_clk && pclk && ser_dat != pdat) seq_bad = 1;
                end
                if (pcs != 2'b11 && ser_cs_n == 2'b11) begin
                    frames_seen++;
                    check(!seq_bad && nbits == 16, "R4 bit sequence", nbits, 16);
                    if (exp_q.size() == 0) begin
                        check(0, "R6 unexpected frame", {tgt, sh}, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check({tgt, sh} == e, "R1 R3 R8 frame", {tgt, sh}, e);
                    end
                end
                pclk = ser_clk; pdat = ser_dat; pcs = ser_cs_n;
            end
        end
    end

    task automatic send(input logic [2:0] chip, input logic [4:0] addr,
                        input logic [7:0] data, input logic [7:0] mask,
                        input bit noise);
        logic [7:0] nv;
        int n;
        int c;
        c = (chip != 0) ? 1 : 0;
        nv = (model[c][addr] & ~mask) | (data & mask);
        model[c][addr] = nv;
        exp_q.push_back({c[0], 3'b101, addr, nv});
        frames_pushed++;
        @(negedge clk);
        req_valid = 1; req_chip = chip; req_addr = addr; req_data = data; req_mask = mask;
        @(negedge clk);
        req_valid = 0;
        check(busy == 1'b1, "R6 accept sets busy", busy, 1);
        n = 1;
        while (!done && n < 1000) begin
            if (noise && n == 10) begin
                req_valid = 1; req_chip = 3'd0; req_addr = addr; req_data = ~data; req_mask = 8'hFF;
            end
            if (noise && n == 12) req_valid = 0;
            @(negedge clk);
            n++;
        end
        req_valid = 0;
        check(n == 51 * P, "R7 R9 transfer length", n, 51 * P);
        @(negedge clk);
        check(!done && !busy, "R7 done single cycle", {done, busy}, 0);
        check(ser_clk && ser_dat && ser_cs_n == 2'b11, "R2 parked after done",
              {ser_clk, ser_dat, ser_cs_n}, 4'hF);
    endtask

    initial begin
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 32; r++) model[c][r] = 8'h00;
        repeat (3) @(negedge clk);
        check(ser_clk && ser_dat && ser_cs_n == 2'b11 && !busy && !done,
              "R2 reset state", {ser_clk, ser_dat, ser_cs_n, busy, done}, 6'h3C);
        rst_n = 1;
        @(negedge clk);
        send(3'd0, 5'h02, 8'hA5, 8'hFF, 0);
        send(3'd1, 5'h1F, 8'h3C, 8'hFF, 0);
        send(3'd0, 5'h02, 8'h0F, 8'h0F, 0);   // R8 merge with shadow
        send(3'd3, 5'h1F, 8'hFF, 8'h80, 0);   // R3 index 3 -> second select, R8 shared shadow
        send(3'd2, 5'h10, 8'h81, 8'hF0, 1);   // R6 requests while busy
        send(3'd0, 5'h00, 8'h00, 8'hFF, 0);
        // R5 rejected index
        @(negedge clk);
        req_valid = 1; req_chip = 3'd5; req_addr = 5'h01; req_data = 8'h11; req_mask = 8'hFF;
        @(negedge clk);
        req_valid = 0;
        begin
            bit quiet;
            quiet = 1;
            for (int i = 0; i < 4 * P; i++) begin
                if (busy || ser_cs_n != 2'b11) quiet = 0;
                @(negedge clk);
            end
            check(quiet, "R5 index 4+ rejected", {busy, ser_cs_n}, 3'b011);
        end
        send(3'd1, 5'h01, 8'h5A, 8'hFF, 0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && frames_seen == frames_pushed, "R6 frame count",
              frames_seen, frames_pushed);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule